// File: doc/BRIEF.md
# Video Controller Command Port Decoder

This block sits behind the control and data ports of a video controller. Every 16-bit word written to the control port is either a one-word register load or one half of a two-word access command. The command's access code and target address are spread over both words, so the block keeps a flag that says whether a second word is due. That flag decides how the next control word is read. Any data-port access or status read drops the flag.

For data-port traffic, the block turns the current access code into a strobe towards one of three memories: video RAM, colour RAM or scroll RAM. It places the write data on the correct byte lanes and returns read data, or zero when the access is not permitted. After each accepted access it steps the address by the auto-increment register.

When a command's second word asks for a DMA and DMA is enabled, the block issues a one-cycle request and holds the transfer mode. It also tracks whether the transfer is busy. A fill transfer does not count as busy until its data word arrives. The transfer engine itself lives outside.

Top module: `vdp_cmd_port`

## Requirements
- R1: After reset, `cmd_pend`, `acc_code`, `acc_addr`, `autoinc`, `dma_req`, `dma_busy` and `fill_byte` are all zero.
- R2: A control word written with no second word pending, whose bits 15:14 equal binary 10, loads register number bits 12:8 with bits 7:0 and leaves `cmd_pend` at 0. Register 15 drives `autoinc`, register 1 bit 4 enables DMA, and register 23 bits 7:6 select the DMA mode.
- R3: Any other control word with no second word pending sets `cmd_pend`. It copies word bits 15:14 into code bits 1:0 and word bits 13:0 into address bits 13:0, and keeps address bits 15:14.
- R4: A control word written while `cmd_pend` is 1 is always a second word, even when its bits 15:14 are 10. It loads code bit 5 from word bit 7, code bits 4:2 from word bits 6:4 and address bits 15:14 from word bits 1:0. It keeps the other code and address bits and clears `cmd_pend`.
- R5: A data-port access or a status read (`stat_rd`) clears `cmd_pend` and leaves the code and address unchanged, so the next control word is taken as a first word.
- R6: A second word with bit 7 set, while DMA is enabled, raises `dma_req` for exactly the one cycle after the write. `dma_mode` is register 23 bits 7:6, with 0 replaced by 1 (1 memory-to-video, 2 fill, 3 video copy). With DMA disabled no request is made.
- R7: Code bits 3:0 select the data-port operation in the cycle of the access. The values are 0 video read, 1 video write, 3 colour write, 4 scroll read, 5 scroll write and 8 colour read. `mem_tgt` is 1 for video, 2 for colour and 3 for scroll. Read data comes back on `data_rdata` in the same cycle.
- R8: An access whose code is not listed for its direction makes no memory strobe, returns 0, and leaves the address unchanged.
- R9: Every accepted access adds `autoinc` to the address. For colour and scroll accesses the result is cut to 7 bits. For video accesses it wraps at 16 bits.
- R10: A scroll access at a 7-bit address of 80 or more makes no memory strobe and reads as 0, but still advances the address.
- R11: A video write to an odd address swaps the two data bytes and keeps the caller's byte-lane mask. An even address passes the data unchanged. Colour and scroll writes use both lanes and a 7-bit `mem_addr`.
- R12: `dma_busy` goes high after a memory-to-video or copy request and stays high until `dma_done`. After a fill request it stays low until a data write arrives. That write latches bits 15:8 into `fill_byte`, makes no memory strobe and no address step, and sets `dma_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_wr | input | 1 | Control-port write strobe |
| ctrl_wdata | input | 16 | Control-port word |
| stat_rd | input | 1 | Status-port read strobe |
| data_acc | input | 1 | Data-port access strobe |
| data_we | input | 1 | Data-port direction, 1 = write |
| data_wdata | input | 16 | Data-port write word |
| data_be | input | 2 | Byte lanes of a data write, bit 1 = bits 15:8 |
| data_rdata | output | 16 | Data-port read word |
| mem_en | output | 1 | Memory strobe |
| mem_we | output | 1 | Memory write enable |
| mem_tgt | output | 2 | Target memory: 1 video, 2 colour, 3 scroll |
| mem_addr | output | 16 | Byte address into the target memory |
| mem_wdata | output | 16 | Memory write word after lane swap |
| mem_be | output | 2 | Memory byte lanes |
| mem_rdata | input | 16 | Word read from the target memory |
| dma_done | input | 1 | Transfer engine has finished |
| acc_code | output | 6 | Current access code |
| acc_addr | output | 16 | Current access address |
| autoinc | output | 8 | Auto-increment register |
| cmd_pend | output | 1 | Second command word is expected |
| dma_req | output | 1 | One-cycle DMA start request |
| dma_mode | output | 2 | DMA mode of the last request |
| dma_busy | output | 1 | DMA transfer in progress |
| fill_byte | output | 8 | Latched fill value |

## Verification
Memory strobe, target, address, lane mask, write data and read data are combinational. They are due in the same cycle as the data strobe, so the bench checks them mid-cycle, before the closing edge. Pending flag, code, address, registers, `dma_req`, `dma_mode`, `dma_busy` and `fill_byte` pass through one register. They are due in the cycle after the strobe's edge, and the bench samples them 1 ns after that edge. `dma_req` is expected high in that single cycle and low again one cycle later.

// File: rtl/vdp_cmd_pkg.sv
package vdp_cmd_pkg;
  localparam int ADDR_W       = 16;
  localparam int WORD_W       = 16;
  localparam int CODE_W       = 6;
  localparam int REG_W        = 8;
  localparam int REG_N        = 32;
  localparam int REG_IDX_W    = $clog2(REG_N);
  localparam int MODE2_IDX    = 1;
  localparam int DMA_EN_BIT   = 4;
  localparam int INC_IDX      = 15;
  localparam int DMA_SRC_IDX  = 23;
  localparam int SMALL_ADDR_W = 7;
  localparam int SCROLL_LIMIT = 80;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_VRAM  = 2'd1,
    TGT_CRAM  = 2'd2,
    TGT_VSRAM = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    DS_IDLE      = 2'd0,
    DS_RUN       = 2'd1,
    DS_FILL_WAIT = 2'd2
  } dma_st_e;

  typedef struct packed {
    logic valid;
    logic wr;
    tgt_e tgt;
  } port_op_t;

  // Maps code bits 3:0 to target and direction.
  function automatic port_op_t decode_op(input logic [3:0] c);
    port_op_t o;
    o = '{1'b0, 1'b0, TGT_NONE};
    case (c)
      4'd0:    o = '{1'b1, 1'b0, TGT_VRAM};
      4'd1:    o = '{1'b1, 1'b1, TGT_VRAM};
      4'd3:    o = '{1'b1, 1'b1, TGT_CRAM};
      4'd4:    o = '{1'b1, 1'b0, TGT_VSRAM};
      4'd5:    o = '{1'b1, 1'b1, TGT_VSRAM};
      4'd8:    o = '{1'b1, 1'b0, TGT_CRAM};
      default: o = '{1'b0, 1'b0, TGT_NONE};
    endcase
    return o;
  endfunction

  function automatic logic [ADDR_W-1:0] small_addr(input logic [ADDR_W-1:0] a);
    return a & ADDR_W'((1 << SMALL_ADDR_W) - 1);
  endfunction

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                  input logic [REG_W-1:0]  inc,
                                                  input tgt_e              t);
    logic [ADDR_W-1:0] s;
    s = a + ADDR_W'(inc);
    if (t != TGT_VRAM) s = small_addr(s);
    return s;
  endfunction

  function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
    return {w[WORD_W/2-1:0], w[WORD_W-1:WORD_W/2]};
  endfunction

  function automatic logic [1:0] fix_mode(input logic [1:0] m);
    return (m == 2'd0) ? 2'd1 : m;
  endfunction
endpackage

// File: rtl/vdp_cmd_decoder.sv
module vdp_cmd_decoder
  import vdp_cmd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [WORD_W-1:0]    wdata,
  input  logic                 clr_pend,
  input  logic                 adv,
  input  logic [ADDR_W-1:0]    adv_addr,
  input  logic                 dma_en,
  output logic                 pend,
  output logic [CODE_W-1:0]    code,
  output logic [ADDR_W-1:0]    addr,
  output logic                 ev_reg_load,
  output logic                 ev_first,
  output logic                 ev_second,
  output logic                 ev_dma_kick,
  output logic [REG_IDX_W-1:0] reg_idx,
  output logic [REG_W-1:0]     reg_val
);
  localparam int LO_W = ADDR_W - 2;

  always_comb begin
    ev_reg_load = wr && !pend && (wdata[WORD_W-1 -: 2] == 2'b10);
    ev_first    = wr && !pend && !ev_reg_load;
    ev_second   = wr && pend;
    ev_dma_kick = ev_second && wdata[7] && dma_en;
  end

  assign reg_idx = wdata[8 +: REG_IDX_W];
  assign reg_val = wdata[REG_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      code <= '0;
      addr <= '0;
    end else if (ev_reg_load) begin
      pend <= 1'b0;
    end else if (ev_first) begin
      pend              <= 1'b1;
      code[1:0]         <= wdata[WORD_W-1 -: 2];
      addr[LO_W-1:0]    <= wdata[LO_W-1:0];
    end else if (ev_second) begin
      pend              <= 1'b0;
      code[CODE_W-1:2]  <= {wdata[7], wdata[6:4]};
      addr[ADDR_W-1 -: 2] <= wdata[1:0];
    end else begin
      if (clr_pend) pend <= 1'b0;
      if (adv)      addr <= adv_addr;
    end
  end
endmodule

// File: rtl/vdp_reg_bank.sv
module vdp_reg_bank
  import vdp_cmd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [REG_IDX_W-1:0] idx,
  input  logic [REG_W-1:0]     val,
  output logic [REG_W-1:0]     inc_val,
  output logic                 dma_en,
  output logic [1:0]           dma_sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inc_val <= '0;
    else if (we && idx == REG_IDX_W'(INC_IDX)) inc_val <= val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dma_en <= 1'b0;
    else if (we && idx == REG_IDX_W'(MODE2_IDX)) dma_en <= val[DMA_EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dma_sel <= 2'd0;
    else if (we && idx == REG_IDX_W'(DMA_SRC_IDX)) dma_sel <= val[REG_W-1 -: 2];
  end
endmodule

// File: rtl/vdp_dma_ctl.sv
module vdp_dma_ctl
  import vdp_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic [1:0]       src_sel,
  input  logic             fill_wr,
  input  logic [REG_W-1:0] fill_val,
  input  logic             done,
  output logic             req,
  output logic [1:0]       mode,
  output logic             busy,
  output logic             fill_wait,
  output logic [REG_W-1:0] fill_byte
);
  dma_st_e    st;
  logic [1:0] next_mode;

  assign next_mode = fix_mode(src_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= DS_IDLE;
      req       <= 1'b0;
      mode      <= 2'd0;
      fill_byte <= '0;
    end else begin
      req <= kick;
      if (kick) begin
        mode <= next_mode;
        st   <= (next_mode == 2'd2) ? DS_FILL_WAIT : DS_RUN;
      end else if (st == DS_FILL_WAIT && fill_wr) begin
        st        <= DS_RUN;
        fill_byte <= fill_val;
      end else if (st == DS_RUN && done) begin
        st <= DS_IDLE;
      end
    end
  end

  assign busy      = (st == DS_RUN);
  assign fill_wait = (st == DS_FILL_WAIT);
endmodule

// File: rtl/vdp_data_port.sv
module vdp_data_port
  import vdp_cmd_pkg::*;
(
  input  logic              acc,
  input  logic              we,
  input  logic [3:0]        op_code,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  inc,
  input  logic [WORD_W-1:0] wdata,
  input  logic [1:0]        be,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              fill_wait,
  output logic              mem_en,
  output logic              mem_we,
  output tgt_e              mem_tgt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [1:0]        mem_be,
  output logic [WORD_W-1:0] rdata,
  output logic              adv,
  output logic [ADDR_W-1:0] adv_addr,
  output logic              fill_wr
);
  port_op_t op;
  logic     live;
  logic     in_win;
  tgt_e     tgt;

  always_comb begin
    op        = decode_op(op_code);
    fill_wr   = acc && we && fill_wait;
    live      = acc && !fill_wr && op.valid && (op.wr == we);
    tgt       = live ? op.tgt : TGT_NONE;
    mem_addr  = (tgt == TGT_VRAM) ? addr : small_addr(addr);
    in_win    = (tgt != TGT_VSRAM) || (mem_addr < ADDR_W'(SCROLL_LIMIT));
    mem_en    = live && in_win;
    mem_we    = mem_en && we;
    mem_tgt   = mem_en ? tgt : TGT_NONE;
    mem_wdata = (tgt == TGT_VRAM && addr[0]) ? swap_bytes(wdata) : wdata;
    mem_be    = (tgt == TGT_VRAM) ? be : 2'b11;
    rdata     = (mem_en && !we) ? mem_rdata : '0;
    adv       = live;
    adv_addr  = step_addr(addr, inc, tgt);
  end
endmodule

// File: rtl/vdp_cmd_port.sv
module vdp_cmd_port
  import vdp_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [WORD_W-1:0] ctrl_wdata,
  input  logic              stat_rd,
  input  logic              data_acc,
  input  logic              data_we,
  input  logic [WORD_W-1:0] data_wdata,
  input  logic [1:0]        data_be,
  output logic [WORD_W-1:0] data_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [1:0]        mem_tgt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [1:0]        mem_be,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              dma_done,
  output logic [CODE_W-1:0] acc_code,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [REG_W-1:0]  autoinc,
  output logic              cmd_pend,
  output logic              dma_req,
  output logic [1:0]        dma_mode,
  output logic              dma_busy,
  output logic [REG_W-1:0]  fill_byte
);
  logic                 ev_reg_load, ev_first, ev_second, ev_dma_kick;
  logic                 ev_clr_pend, ev_adv, ev_fill_wr;
  logic [ADDR_W-1:0]    adv_addr;
  logic [REG_IDX_W-1:0] reg_idx;
  logic [REG_W-1:0]     reg_val;
  logic                 dma_en;
  logic [1:0]           dma_sel;
  logic                 fill_wait;
  tgt_e                 tgt_sel;

  assign ev_clr_pend = data_acc || stat_rd;

  vdp_cmd_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(ctrl_wdata),
    .clr_pend(ev_clr_pend), .adv(ev_adv), .adv_addr(adv_addr), .dma_en(dma_en),
    .pend(cmd_pend), .code(acc_code), .addr(acc_addr),
    .ev_reg_load(ev_reg_load), .ev_first(ev_first), .ev_second(ev_second),
    .ev_dma_kick(ev_dma_kick), .reg_idx(reg_idx), .reg_val(reg_val)
  );

  vdp_reg_bank u_regs (
    .clk(clk), .rst_n(rst_n), .we(ev_reg_load), .idx(reg_idx), .val(reg_val),
    .inc_val(autoinc), .dma_en(dma_en), .dma_sel(dma_sel)
  );

  vdp_dma_ctl u_dma (
    .clk(clk), .rst_n(rst_n), .kick(ev_dma_kick), .src_sel(dma_sel),
    .fill_wr(ev_fill_wr), .fill_val(data_wdata[WORD_W-1 -: REG_W]), .done(dma_done),
    .req(dma_req), .mode(dma_mode), .busy(dma_busy), .fill_wait(fill_wait),
    .fill_byte(fill_byte)
  );

  vdp_data_port u_port (
    .acc(data_acc), .we(data_we), .op_code(acc_code[3:0]), .addr(acc_addr),
    .inc(autoinc), .wdata(data_wdata), .be(data_be), .mem_rdata(mem_rdata),
    .fill_wait(fill_wait), .mem_en(mem_en), .mem_we(mem_we), .mem_tgt(tgt_sel),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be), .rdata(data_rdata),
    .adv(ev_adv), .adv_addr(adv_addr), .fill_wr(ev_fill_wr)
  );

  assign mem_tgt = tgt_sel;
endmodule

// File: rtl/vdp_cmd_port_chk.sv
module vdp_cmd_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctrl_wr,
  input logic [1:0]  cw_top,
  input logic [13:0] cw_low,
  input logic [3:0]  cw_code,
  input logic [1:0]  cw_hi_addr,
  input logic        data_acc,
  input logic        stat_rd,
  input logic        cmd_pend,
  input logic [5:0]  acc_code,
  input logic [15:0] acc_addr,
  input logic        dma_req,
  input logic [1:0]  dma_mode,
  input logic        mem_en,
  input logic [1:0]  mem_tgt,
  input logic [15:0] mem_addr,
  input logic        ev_reg_load,
  input logic        ev_first,
  input logic        ev_second
);
  // R2
  reg_load_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reg_load |=> !cmd_pend);

  // R3
  first_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_first |=> cmd_pend);

  // R3
  first_loads_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_first |=> (acc_addr[13:0] == $past(cw_low)) && (acc_code[1:0] == $past(cw_top)));

  // R4
  second_loads_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_second |=> !cmd_pend && (acc_addr[15:14] == $past(cw_hi_addr))
                  && (acc_code[5:2] == $past(cw_code)));

  // R4
  pend_word_is_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && cmd_pend) |-> ev_second);

  // R5
  access_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && (data_acc || stat_rd)) |=> !cmd_pend);

  // R6
  dma_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> !dma_req);

  // R6
  dma_mode_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (dma_mode != 2'd0));

  // R8
  strobe_has_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (mem_tgt != 2'd0));

  // R9
  addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && !data_acc) |=> $stable(acc_addr));

  // R10
  scroll_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_tgt == 2'd3) |-> (mem_addr < 16'd80));
endmodule

bind vdp_cmd_port vdp_cmd_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
  .cw_top(ctrl_wdata[15:14]), .cw_low(ctrl_wdata[13:0]),
  .cw_code(ctrl_wdata[7:4]), .cw_hi_addr(ctrl_wdata[1:0]),
  .data_acc(data_acc), .stat_rd(stat_rd), .cmd_pend(cmd_pend),
  .acc_code(acc_code), .acc_addr(acc_addr), .dma_req(dma_req), .dma_mode(dma_mode),
  .mem_en(mem_en), .mem_tgt(mem_tgt), .mem_addr(mem_addr),
  .ev_reg_load(ev_reg_load), .ev_first(ev_first), .ev_second(ev_second)
);

// File: tb/sim_vdp_cmd_port.sv
`timescale 1ns/1ps
module sim_vdp_cmd_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic        stat_rd = 1'b0;
  logic        data_acc = 1'b0;
  logic        data_we = 1'b0;
  logic [15:0] data_wdata = '0;
  logic [1:0]  data_be = 2'b11;
  logic [15:0] data_rdata;
  logic        mem_en, mem_we;
  logic [1:0]  mem_tgt;
  logic [15:0] mem_addr, mem_wdata;
  logic [1:0]  mem_be;
  logic [15:0] mem_rdata;
  logic        dma_done = 1'b0;
  logic [5:0]  acc_code;
  logic [15:0] acc_addr;
  logic [7:0]  autoinc;
  logic        cmd_pend, dma_req, dma_busy;
  logic [1:0]  dma_mode;
  logic [7:0]  fill_byte;

  int n_run = 0;
  int n_fail = 0;

  // behavioural memories
  logic [15:0] vram [2048];
  logic [15:0] cram [64];
  logic [15:0] vsram [40];

  // reference model state
  logic        m_pend = 1'b0;
  logic [5:0]  m_code = '0;
  logic [15:0] m_addr = '0;
  logic [7:0]  m_inc = '0;
  logic        m_en = 1'b0;
  logic [1:0]  m_sel = '0;
  int          m_dst = 0;
  logic [1:0]  m_mode = '0;
  logic [7:0]  m_fill = '0;

  always #10 clk = ~clk;

  vdp_cmd_port u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .stat_rd(stat_rd), .data_acc(data_acc), .data_we(data_we),
    .data_wdata(data_wdata), .data_be(data_be), .data_rdata(data_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_tgt(mem_tgt), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
    .dma_done(dma_done), .acc_code(acc_code), .acc_addr(acc_addr),
    .autoinc(autoinc), .cmd_pend(cmd_pend), .dma_req(dma_req),
    .dma_mode(dma_mode), .dma_busy(dma_busy), .fill_byte(fill_byte)
  );

  always_comb begin
    mem_rdata = 16'h0000;
    case (mem_tgt)
      2'd1: mem_rdata = vram[mem_addr[11:1]];
      2'd2: mem_rdata = cram[mem_addr[6:1]];
      2'd3: if (mem_addr[6:1] < 6'd40) mem_rdata = vsram[mem_addr[6:1]];
      default: mem_rdata = 16'h0000;
    endcase
  end

  always @(posedge clk) begin
    if (mem_en && mem_we) begin
      case (mem_tgt)
        2'd1: begin
          if (mem_be[1]) vram[mem_addr[11:1]][15:8] <= mem_wdata[15:8];
          if (mem_be[0]) vram[mem_addr[11:1]][7:0]  <= mem_wdata[7:0];
        end
        2'd2: cram[mem_addr[6:1]] <= mem_wdata;
        2'd3: if (mem_addr[6:1] < 6'd40) vsram[mem_addr[6:1]] <= mem_wdata;
        default: ;
      endcase
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  // bench view of the operation table (R7): 1 video, 2 colour, 3 scroll
  function automatic int ref_target(input logic [3:0] c, input bit we);
    if (we) begin
      if (c == 4'd1) return 1;
      if (c == 4'd3) return 2;
      if (c == 4'd5) return 3;
    end else begin
      if (c == 4'd0) return 1;
      if (c == 4'd8) return 2;
      if (c == 4'd4) return 3;
    end
    return 0;
  endfunction

  function automatic logic [15:0] ref_step(input logic [15:0] a, input logic [7:0] inc, input int t);
    logic [15:0] s;
    s = a + {8'h00, inc};
    if (t != 1) s = s % 16'd128;
    return s;
  endfunction

  task automatic check_state(input string tag);
    chk({tag, " pend"}, cmd_pend, m_pend);
    chk({tag, " code"}, acc_code, m_code);
    chk({tag, " addr"}, acc_addr, m_addr);
    chk({tag, " autoinc"}, autoinc, m_inc);
    chk({tag, " busy R12"}, dma_busy, (m_dst == 1));
    chk({tag, " fill R12"}, fill_byte, m_fill);
  endtask

  task automatic do_ctrl(input logic [15:0] w, input string tag);
    bit exp_req;
    ctrl_wr = 1'b1;
    ctrl_wdata = w;
    cyc();
    ctrl_wr = 1'b0;
    exp_req = 1'b0;
    if (!m_pend && w[15:14] == 2'b10) begin
      if (w[12:8] == 5'd15) m_inc = w[7:0];
      if (w[12:8] == 5'd1)  m_en = w[4];
      if (w[12:8] == 5'd23) m_sel = w[7:6];
    end else if (!m_pend) begin
      m_pend = 1'b1;
      m_code[1:0] = w[15:14];
      m_addr[13:0] = w[13:0];
    end else begin
      m_pend = 1'b0;
      m_code[5:2] = {w[7], w[6:4]};
      m_addr[15:14] = w[1:0];
      if (w[7] && m_en) begin
        exp_req = 1'b1;
        m_mode = (m_sel == 2'd0) ? 2'd1 : m_sel;
        m_dst = (m_mode == 2'd2) ? 2 : 1;
      end
    end
    check_state(tag);
    chk({tag, " req R6"}, dma_req, exp_req);
    if (exp_req) chk({tag, " mode R6"}, dma_mode, m_mode);
  endtask

  task automatic do_data(input bit we, input logic [15:0] wd, input logic [1:0] be, input string tag);
    int t;
    bit fillwr, en;
    logic [15:0] ea, ew, er;
    logic [1:0] eb;
    data_acc = 1'b1;
    data_we = we;
    data_wdata = wd;
    data_be = be;
    #2;
    fillwr = we && (m_dst == 2);
    t = fillwr ? 0 : ref_target(m_code[3:0], we);
    ea = (t == 1) ? m_addr : (m_addr % 16'd128);
    en = (t != 0) && (t != 3 || ea < 16'd80);
    ew = (t == 1 && m_addr[0]) ? {wd[7:0], wd[15:8]} : wd;
    eb = (t == 1) ? be : 2'b11;
    er = 16'h0000;
    if (en && !we) begin
      if (t == 1) er = vram[ea[11:1]];
      else if (t == 2) er = cram[ea[6:1]];
      else er = vsram[ea[6:1]];
    end
    chk({tag, " mem_en R7 R8 R10"}, mem_en, en);
    if (en) begin
      chk({tag, " tgt R7"}, mem_tgt, t[1:0]);
      chk({tag, " maddr R11"}, mem_addr, ea);
      chk({tag, " mwe R7"}, mem_we, we);
      if (we) begin
        chk({tag, " wdata R11"}, mem_wdata, ew);
        chk({tag, " be R11"}, mem_be, eb);
      end
    end
    if (!we) chk({tag, " rdata R7 R8 R10"}, data_rdata, er);
    cyc();
    data_acc = 1'b0;
    data_we = 1'b0;
    if (t != 0) m_addr = ref_step(m_addr, m_inc, t);
    m_pend = 1'b0;
    if (fillwr) begin
      m_fill = wd[15:8];
      m_dst = 1;
    end
    check_state({tag, " R9"});
    chk({tag, " req R6"}, dma_req, 1'b0);
  endtask

  task automatic do_status(input string tag);
    stat_rd = 1'b1;
    cyc();
    stat_rd = 1'b0;
    m_pend = 1'b0;
    check_state(tag);
  endtask

  task automatic do_done(input string tag);
    dma_done = 1'b1;
    cyc();
    dma_done = 1'b0;
    if (m_dst == 1) m_dst = 0;
    check_state(tag);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) vram[i] = '0;
    for (int i = 0; i < 64; i++) cram[i] = '0;
    for (int i = 0; i < 40; i++) vsram[i] = '0;
    void'($urandom(32'd4242));
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    check_state("R1 reset");
    chk("R1 req", dma_req, 1'b0);

    // R2 register load sets auto-increment
    do_ctrl(16'h8F02, "R2 inc load");
    chk("R2 autoinc value", autoinc, 8'h02);

    // R3/R4 two-word command, video write at odd address
    do_ctrl(16'h4001, "R3 first word");
    chk("R3 pend set", cmd_pend, 1'b1);
    do_ctrl(16'h0000, "R4 second word");
    do_data(1'b1, 16'h1234, 2'b11, "R11 odd swap");
    chk("R9 addr step", acc_addr, 16'h0003);

    // R7 video read back from word 0
    do_ctrl(16'h0000, "R3 vread first");
    do_ctrl(16'h0000, "R4 vread second");
    do_data(1'b0, 16'h0000, 2'b11, "R7 video read");

    // R4 pending word with top bits 10 is a second word
    do_ctrl(16'h4000, "R4 pre");
    do_ctrl(16'h8F10, "R4 not reg load");
    chk("R4 code value", acc_code, 6'd5);
    chk("R4 autoinc kept", autoinc, 8'h02);

    // R9 colour write wraps at 7 bits
    do_ctrl(16'hC07E, "R3 cram first");
    do_ctrl(16'h0000, "R4 cram second");
    do_data(1'b1, 16'h0ABC, 2'b01, "R11 cram write");
    chk("R9 cram wrap", acc_addr, 16'h0000);

    // R7 colour read of entry at 0x7E
    do_ctrl(16'h007E, "R3 cread first");
    do_ctrl(16'h0020, "R4 cread second");
    chk("R7 code 8", acc_code, 6'd8);
    do_data(1'b0, 16'h0000, 2'b11, "R7 colour read");
    chk("R7 colour value", data_rdata, 16'h0000);

    // R10 scroll window
    do_ctrl(16'h404E, "R3 vs first");
    do_ctrl(16'h0010, "R4 vs second");
    do_data(1'b1, 16'h5555, 2'b11, "R10 in window");
    do_data(1'b1, 16'h6666, 2'b11, "R10 out of window");
    chk("R10 step past 80", acc_addr, 16'h0052);
    do_ctrl(16'h0050, "R3 vsr first");
    do_ctrl(16'h0010, "R4 vsr second");
    do_data(1'b0, 16'h0000, 2'b11, "R10 read out of window");

    // R8 unused code and direction mismatch
    do_ctrl(16'hC000, "R3 code7 first");
    do_ctrl(16'h0010, "R4 code7 second");
    do_data(1'b1, 16'hFFFF, 2'b11, "R8 code 7 write");
    chk("R8 addr kept", acc_addr, 16'h0000);
    do_ctrl(16'h4010, "R3 c1 first");
    do_ctrl(16'h0000, "R4 c1 second");
    do_data(1'b0, 16'h0000, 2'b11, "R8 read with write code");

    // R5 status read drops the pending flag
    do_ctrl(16'h4123, "R5 first");
    do_status("R5 status clears");
    do_ctrl(16'h0456, "R5 next is first");
    chk("R5 pend after", cmd_pend, 1'b1);
    do_data(1'b0, 16'h0000, 2'b11, "R5 data clears");

    // R6 DMA disabled: no request
    do_ctrl(16'h4000, "R6 off first");
    do_ctrl(16'h0080, "R6 off second");
    // R6/R12 mode 0 promoted to 1
    do_ctrl(16'h8110, "R6 enable");
    do_ctrl(16'h9700, "R6 mode 0");
    do_ctrl(16'h4000, "R6 first");
    do_ctrl(16'h0080, "R6 kick");
    chk("R6 mode promoted", dma_mode, 2'd1);
    chk("R12 busy", dma_busy, 1'b1);
    cyc();
    chk("R6 single pulse", dma_req, 1'b0);
    do_done("R12 done");
    // R12 fill waits for data
    do_ctrl(16'h9780, "R6 mode fill");
    do_ctrl(16'h4000, "R12 fill first");
    do_ctrl(16'h0080, "R12 fill kick");
    chk("R12 fill not busy", dma_busy, 1'b0);
    do_data(1'b1, 16'hAB00, 2'b11, "R12 fill data");
    chk("R12 fill byte", fill_byte, 8'hAB);
    do_done("R12 fill done");

    // random mix
    for (int k = 0; k < 600; k++) begin
      int r;
      r = $urandom % 12;
      if (r < 2 && !m_pend) begin
        int pick;
        logic [4:0] idx;
        pick = $urandom % 3;
        idx = (pick == 0) ? 5'd1 : (pick == 1) ? 5'd15 : 5'd23;
        do_ctrl({3'b100, idx, 8'($urandom)}, "R2 rand reg");
      end else if (r < 6) begin
        logic [15:0] w;
        w = 16'($urandom);
        if (m_pend && ($urandom % 4) != 0) w[7] = 1'b0;
        do_ctrl(w, "R3 R4 rand ctrl");
      end else if (r < 10) begin
        do_data(1'($urandom), 16'($urandom), 2'($urandom), "R7 rand data");
      end else if (r == 10) begin
        do_status("R5 rand status");
      end else begin
        do_done("R12 rand done");
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule